// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR flash and decides when an internal program or erase algorithm has ended. It needs no knowledge of how long the operation takes. Instead it reads the status byte at a chosen address over and over, in pairs. It compares the main toggle bit (bit 6) between the two reads of a pair, and looks at the time-limit bit (bit 5) and the secondary toggle bit (bit 2) when it needs more information.

A one-cycle `start` launches a run and samples three inputs: the polling address, the test mode and an iteration budget. The polling address must be the address being programmed, or an address inside a sector chosen for erasure. In completion mode the block reports one of three results: complete, timed out, or budget exhausted. In suspend-test mode it reports whether the sector at the polling address is erase-suspended. Reads go out through a request/acknowledge pair toward a separate bus-timing unit. On a time-out the block pulses `reset_req`, so that the surrounding logic can send the read/reset command.

Top module: `flash_toggle_poller`

## Requirements
- R1: If bit 6 has the same value in both reads of a pair, the run ends with result code 1 (complete).
- R2: In completion mode, if bit 6 differs within a pair and bit 5 of the second read is 0, another pair is read. The run therefore issues exactly two reads per pair examined.
- R3: In completion mode, if bit 6 differs and bit 5 of the second read is 1, one more pair is read. The result is code 1 if bit 6 is equal in that pair, and code 2 (time-out) if it still differs.
- R4: In suspend-test mode (`mode_susp`=1), if bit 6 differs in the first pair, one more pair is read. The result is code 4 (suspended) if bit 2 differs in that pair, and code 5 (not suspended) if it does not.
- R5: `reset_req` pulses for exactly one cycle, in the same cycle as `done`, when the result is code 2. It is never high at any other time.
- R6: In completion mode, reaching the `max_polls`-th looping pair ends the run with code 3 (budget exhausted) and no further read. A `max_polls` of 0 behaves as 1.
- R7: `rd_req` stays high until a cycle in which `rd_ack` is high. `rd_addr` equals the address sampled at start for the whole run.
- R8: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start until `done`. `result` and `last_status` hold their values until the next accepted start, which clears `result` to code 0.
- R9: A `start` while `busy` is high has no effect on the running operation: same result, same number of reads, same address.
- R10: After reset, `busy`, `done`, `rd_req` and `reset_req` are 0 and `result` is code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run (ignored while busy) |
| mode_susp | input | 1 | 0 = completion test, 1 = suspend test |
| poll_addr | input | ADDR_W | Address polled during the run |
| max_polls | input | CNT_W | Looping-pair budget |
| rd_req | output | 1 | Read request toward the bus unit |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read complete, `rd_data` valid |
| rd_data | input | DATA_W | Status byte returned by the flash |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 3 | 0 none, 1 complete, 2 time-out, 3 budget, 4 suspended, 5 not suspended |
| last_status | output | DATA_W | Byte from the final read of the run |
| reset_req | output | 1 | Request for a read/reset command |

## Verification
The hardest case to reach is the one where toggling stops in the same read in which bit 5 first reads 1. The poller must then classify the operation as complete and not as timed out, and this depends on the exact read index at which both events occur. The bench's behavioural flash model therefore takes, for each run, the read index at which bit 6 freezes and the read index at which bit 5 rises. Directed runs place these two indices next to each other, so that the last toggling pair carries bit 5 and the recheck pair is stable. Random runs spread both indices widely so that they also meet the loop, time-out and budget paths.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  typedef enum logic [2:0] {
    RES_NONE   = 3'd0,
    RES_DONE   = 3'd1,
    RES_TMO    = 3'd2,
    RES_WDOG   = 3'd3,
    RES_SUSP   = 3'd4,
    RES_NOSUSP = 3'd5
  } res_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RDA,
    ST_RDB
  } st_e;

  typedef enum logic [1:0] {
    PK_MAIN,
    PK_RECHK,
    PK_SUSP
  } pk_e;
endpackage

// File: rtl/ftp_reader.sv
module ftp_reader #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_req,
  output logic [DATA_W-1:0] byte_q,
  output logic              byte_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req   <= 1'b0;
      byte_q   <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (rd_req && rd_ack) begin
        rd_req   <= 1'b0;
        byte_q   <= rd_data;
        byte_vld <= 1'b1;
      end else if (issue) begin
        rd_req <= 1'b1;
      end
    end
  end

  // R7: a request is held until it is acknowledged
  a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> rd_req);
  // R7: a new read is never issued on top of an open one
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    issue |-> !rd_req);
endmodule

// File: rtl/ftp_budget.sv
module ftp_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) remain_q <= '0;
    else if (load) remain_q <= load_val;
    else if (dec) remain_q <= remain_q - ONE;
  end

  assign last = (remain_q <= ONE);

  // R6: the budget never wraps below one
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    dec |-> !last);
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import ftp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int T1_BIT = 6,
  parameter int TO_BIT = 5,
  parameter int T2_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_susp,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic [CNT_W-1:0]  max_polls,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic [2:0]        result,
  output logic [DATA_W-1:0] last_status,
  output logic              reset_req
);
  st_e  st_q, st_n;
  pk_e  pk_q, pk_n;
  res_e res_q, fin_res;
  logic mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic first_t1_q, first_t2_q;
  logic issue, fin, dec, last, vld, accept;
  logic [DATA_W-1:0] byte_q;
  logic done_q, rreq_q;
  logic t1_flip, t2_flip;

  ftp_reader #(.DATA_W(DATA_W)) u_reader (
    .clk(clk), .rst(rst), .issue(issue), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_req(rd_req), .byte_q(byte_q), .byte_vld(vld)
  );

  ftp_budget #(.CNT_W(CNT_W)) u_budget (
    .clk(clk), .rst(rst), .load(accept), .load_val(max_polls),
    .dec(dec), .last(last)
  );

  assign accept  = (st_q == ST_IDLE) && start;
  assign t1_flip = first_t1_q ^ byte_q[T1_BIT];
  assign t2_flip = first_t2_q ^ byte_q[T2_BIT];

  always_comb begin
    st_n    = st_q;
    pk_n    = pk_q;
    issue   = 1'b0;
    fin     = 1'b0;
    fin_res = RES_NONE;
    dec     = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_n  = ST_RDA;
        pk_n  = PK_MAIN;
        issue = 1'b1;
      end
      ST_RDA: if (vld) begin
        st_n  = ST_RDB;
        issue = 1'b1;
      end
      ST_RDB: if (vld) begin
        st_n = ST_RDA;
        case (pk_q)
          PK_MAIN: begin
            if (!t1_flip) begin
              fin = 1'b1; fin_res = RES_DONE;
            end else if (mode_q) begin
              pk_n = PK_SUSP; issue = 1'b1;
            end else if (!byte_q[TO_BIT]) begin
              if (last) begin
                fin = 1'b1; fin_res = RES_WDOG;
              end else begin
                dec = 1'b1; issue = 1'b1;
              end
            end else begin
              pk_n = PK_RECHK; issue = 1'b1;
            end
          end
          PK_RECHK: begin
            fin = 1'b1;
            fin_res = t1_flip ? RES_TMO : RES_DONE;
          end
          default: begin
            fin = 1'b1;
            fin_res = t2_flip ? RES_SUSP : RES_NOSUSP;
          end
        endcase
        if (fin) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      pk_q       <= PK_MAIN;
      mode_q     <= 1'b0;
      addr_q     <= '0;
      first_t1_q <= 1'b0;
      first_t2_q <= 1'b0;
      res_q      <= RES_NONE;
      done_q     <= 1'b0;
      rreq_q     <= 1'b0;
    end else begin
      st_q   <= st_n;
      pk_q   <= pk_n;
      done_q <= fin;
      rreq_q <= fin && (fin_res == RES_TMO);
      if (accept) begin
        mode_q <= mode_susp;
        addr_q <= poll_addr;
        res_q  <= RES_NONE;
      end
      if (st_q == ST_RDA && vld) begin
        first_t1_q <= byte_q[T1_BIT];
        first_t2_q <= byte_q[T2_BIT];
      end
      if (fin) res_q <= fin_res;
    end
  end

  assign rd_addr     = addr_q;
  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign result      = res_q;
  assign reset_req   = rreq_q;
  assign last_status = byte_q;

  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: reset request only alongside a time-out completion
  a_r5_rreq_tmo: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (done && result == 3'd2));
  // R8: result held while idle with no start
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));
  // R7: address fixed during a run
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rd_addr));
  // R9: start while busy leaves the mode alone
  a_r9_ignore: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mode_q));
  // R8: no request outstanding once the run reports
  a_r8_quiet_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_req);
endmodule

// File: tb/flash_toggle_poller_tb.sv
module flash_toggle_poller_tb;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode_susp = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic [CW-1:0] max_polls = '0;
  logic rd_req, busy, done, reset_req;
  logic [AW-1:0] rd_addr;
  logic rd_ack = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic [2:0] result;
  logic [DW-1:0] last_status;

  int nchecks = 0;
  int nerr = 0;
  int rd_idx = 0;
  int op_base = 0;
  int dly = 0;
  int sc_tlen = 0;
  int sc_t5 = 0;
  bit sc_susp = 0;
  logic [AW-1:0] cur_addr = '0;
  int addr_bad = 0;
  int rreq_cnt = 0;

  always #5 clk = ~clk;

  flash_toggle_poller #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode_susp(mode_susp),
    .poll_addr(poll_addr), .max_polls(max_polls), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy),
    .done(done), .result(result), .last_status(last_status),
    .reset_req(reset_req)
  );

  // Status bits of the i-th read of a run: bit6 toggles until read tlen,
  // bit5 rises at read t5, bit2 toggles when the sector is suspended.
  function automatic logic [7:0] mk_bits(int i);
    logic [7:0] b;
    b = 8'h00;
    b[6] = (i < sc_tlen) ? i[0] : sc_tlen[0];
    b[5] = (i >= sc_t5);
    b[2] = sc_susp ? i[0] : 1'b0;
    return b;
  endfunction

  function automatic void predict(bit md, int maxp, output int res, output int nrd);
    int i;
    int rem;
    logic [7:0] a, b;
    i = 0;
    rem = maxp;
    res = 0;
    while (res == 0) begin
      a = mk_bits(i); b = mk_bits(i + 1); i += 2;
      if (a[6] == b[6]) res = 1;
      else if (md) begin
        a = mk_bits(i); b = mk_bits(i + 1); i += 2;
        res = (a[2] != b[2]) ? 4 : 5;
      end else if (!b[5]) begin
        if (rem <= 1) res = 3;
        else rem--;
      end else begin
        a = mk_bits(i); b = mk_bits(i + 1); i += 2;
        res = (a[6] != b[6]) ? 2 : 1;
      end
    end
    nrd = i;
  endfunction

  function automatic string req_of(int r);
    case (r)
      1: return "R1";
      2: return "R3";
      3: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural flash: acknowledges each request after a random delay.
  always @(negedge clk) begin
    if (rst) begin
      rd_ack <= 1'b0;
    end else if (rd_ack) begin
      rd_ack <= 1'b0;
    end else if (rd_req) begin
      if (dly > 0) dly <= dly - 1;
      else begin
        rd_ack  <= 1'b1;
        rd_data <= mk_bits(rd_idx - op_base) | 8'($urandom & 32'h9B);
        rd_idx  <= rd_idx + 1;
        dly     <= int'($urandom % 3);
      end
    end
    if (!rst && rd_req && rd_addr != cur_addr) addr_bad++;
    if (!rst && reset_req) rreq_cnt++;
  end

  task automatic run_op(bit md, logic [AW-1:0] ad, int maxp, int tlen, int t5,
                        bit susp, bit bump, string tag);
    int er, en, cyc, r0;
    bit seen;
    sc_tlen = tlen; sc_t5 = t5; sc_susp = susp;
    predict(md, maxp, er, en);
    @(negedge clk);
    op_base = rd_idx;
    r0 = rreq_cnt;
    cur_addr = ad;
    start = 1'b1; mode_susp = md; poll_addr = ad; max_polls = CW'(maxp);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8", {tag, " busy after start"}, int'(busy), 1);
    seen = 0;
    cyc = 0;
    while (!seen && cyc < 5000) begin
      if (done) seen = 1;
      else begin
        if (bump && cyc == 5) begin
          start = 1'b1; mode_susp = ~md; poll_addr = ~ad; max_polls = CW'(1);
        end else begin
          start = 1'b0; mode_susp = md; poll_addr = ad;
        end
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    chk(seen, req_of(er), {tag, " done seen"}, int'(seen), 1);
    chk(int'(result) == er, bump ? "R9" : req_of(er), {tag, " result"}, int'(result), er);
    chk((rd_idx - op_base) == en, bump ? "R9" : "R2", {tag, " read count"}, rd_idx - op_base, en);
    chk(reset_req == (er == 2), "R5", {tag, " reset_req with done"}, int'(reset_req), int'(er == 2));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8", {tag, " done one cycle"}, int'(done), 0);
    chk(int'(result) == er, "R8", {tag, " result held"}, int'(result), er);
    chk((rreq_cnt - r0) == ((er == 2) ? 1 : 0), "R5", {tag, " reset_req pulses"}, rreq_cnt - r0, int'(er == 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(busy == 0 && done == 0 && rd_req == 0 && reset_req == 0, "R10", "idle outputs", int'(busy), 0);
    chk(result == 3'd0, "R10", "result after reset", int'(result), 0);

    run_op(0, 20'h12345, 10, 0, 99, 0, 0, "R1 immediate");
    run_op(0, 20'h00010, 10, 6, 99, 0, 0, "R2 loops");
    run_op(0, 20'h00020, 10, 100, 3, 0, 0, "R3 timeout");
    run_op(0, 20'h00030, 10, 4, 3, 0, 0, "R3 stop with bit5");
    run_op(0, 20'h00031, 10, 2, 1, 0, 0, "R3 stop with bit5 early");
    run_op(1, 20'h00040, 10, 100, 99, 1, 0, "R4 suspended");
    run_op(1, 20'h00050, 10, 100, 99, 0, 0, "R4 not suspended");
    run_op(1, 20'h00060, 10, 0, 99, 1, 0, "R4 stable is complete");
    run_op(0, 20'h00070, 3, 100, 99, 0, 0, "R6 budget");
    run_op(0, 20'h00080, 0, 100, 99, 0, 0, "R6 zero budget");
    run_op(0, 20'h00090, 1, 2, 99, 0, 0, "R6 budget one completes");
    run_op(0, 20'h000A0, 40, 30, 99, 0, 1, "R9 start while busy");

    for (int k = 0; k < 40; k++) begin
      run_op(bit'($urandom % 2), AW'($urandom), int'($urandom % 9),
             int'($urandom % 21), int'($urandom % 31), bit'($urandom % 2), 0, "rand");
    end

    chk(addr_bad == 0, "R7", "rd_addr tracks start address", addr_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule